// File: doc/BRIEF.md
# Prefetching DMA Read FIFO Engine

This block copies a byte range of memory into an internal byte FIFO. It issues read requests ahead of the consumer so that data is already buffered when it is needed. A start command gives a base address and a length in bytes. The engine splits that range into requests of at most `MAX_REQ` bytes and keeps up to `MAX_PEND` of them outstanding at once. A request goes out only when the FIFO can hold its bytes, counting both the bytes already stored and the bytes promised to requests still in flight. Responses may return in any order. Each one is parked in its request slot, and slots are retired into the FIFO strictly in the order their requests were issued.

The engine reports end-of-block as soon as the last request of a block has been accepted, so a follow-on block can be started while earlier responses are still pending. A stop command abandons the current block: no further requests go out, and any responses that arrive later are thrown away. A flush empties the stored bytes.

The consumer takes fixed chunks of `POP_BYTES` bytes in two ways:
- a valid/ready port that never takes data it does not have;
- a strict pop input that raises an error pulse when too little data is stored.

Memory requests use valid/ready. The memory side may hold `req_ready` low for any number of cycles. `req_valid` depends only on registered state; once raised, it stays high with stable address, length and tag until accepted. The one exception is a stop command, which withdraws it. The response channel has no ready: storage for every response is reserved when its request is issued, so a response is always taken in the cycle it is presented.

Top module: `dmarf_top`

## Requirements
- R1: Each accepted request has a length of 1 to `MAX_REQ` bytes, equal to the smaller of `MAX_REQ` and the bytes left in the block. Addresses run contiguously from the block base and together cover exactly the block length.
- R2: At the moment a request is accepted, at most `MAX_PEND` requests are outstanding including that one. Stored bytes plus the bytes of all live outstanding requests never exceed `FIFO_BYTES`.
- R3: Byte k of `rsp_data` (bits 8k+7:8k) carries the byte at `req_addr`+k, and the response must return the request's `req_tag` on `rsp_tag`. Bytes leave the FIFO in address order whatever the response order. Byte j of `out_data` (bits 8j+7:8j) is the j-th oldest stored byte.
- R4: `end_of_block` is 1 exactly when the next request address equals the block end address, and it is 1 after reset. `eob_evt` is a one-cycle pulse in the cycle after the last request of a block is accepted, once per block.
- R5: `active` is 1 when any request slot is still occupied or `end_of_block` is 0. `idle_evt` pulses for one cycle when `active` falls. Starting a new block at the end of the previous one, while its responses are still pending, gives no idle pulse in between.
- R6: A start while `end_of_block` is 0 is ignored. A start while `end_of_block` is 1 is accepted even with responses outstanding.
- R7: `out_valid` is 1 when at least `POP_BYTES` bytes are stored. A handshake (`out_ready` high) while `out_valid` is low removes nothing.
- R8: A strict pop while fewer than `POP_BYTES` bytes are stored, with no flush in the same cycle, sets `pop_err` for one cycle in the next cycle and removes nothing. A strict pop with enough data removes one chunk.
- R9: After stop, no further requests are issued, `end_of_block` is 1, no `eob_evt` is raised for the abandoned block, and late responses are discarded. `idle_evt` still fires once the last outstanding response has been taken.
- R10: A flush discards all stored bytes. `fill_level` reports the number of stored bytes; it is 0 after reset and after a flush with nothing retired in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a block (honoured only at end of block) |
| cmd_base | input | ADDR_W | Block base byte address |
| cmd_len | input | LEN_W | Block length in bytes |
| cmd_stop | input | 1 | Abandon the current block |
| cmd_flush | input | 1 | Discard all stored bytes |
| req_valid | output | 1 | Read request present |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Request start address |
| req_len | output | RLEN_W | Request length in bytes |
| req_tag | output | TAG_W | Slot tag to return with the response |
| rsp_valid | input | 1 | Response present (always accepted) |
| rsp_tag | input | TAG_W | Tag of the answered request |
| rsp_data | input | 8*MAX_REQ | Response bytes, byte 0 in the low bits |
| out_valid | output | 1 | At least one chunk is stored |
| out_ready | input | 1 | Consumer takes a chunk if one is there |
| out_data | output | 8*POP_BYTES | Oldest chunk, oldest byte in the low bits |
| pop_strict | input | 1 | Strict pop: takes a chunk or flags an error |
| pop_err | output | 1 | Strict pop found too little data |
| fill_level | output | LVL_W | Stored byte count |
| end_of_block | output | 1 | Last request of the block has gone out |
| active | output | 1 | Block still issuing or slots still occupied |
| eob_evt | output | 1 | One-cycle end-of-block pulse |
| idle_evt | output | 1 | One-cycle pulse when active falls |

## Verification
The hardest state to reach is a slot holding response data that cannot retire because an older slot is still waiting for its response. The same applies to a stop arriving while every slot is occupied and no response has come back. The bench's memory model keeps each accepted request in a table with a random delay. It answers a randomly chosen ready entry, so responses regularly overtake older ones. Directed phases hold all responses back until the slots fill, then stop or start a chained block before releasing them.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;
  // Outcome of the consumer side in one cycle
  typedef enum logic [1:0] {
    POP_NONE  = 2'd0,
    POP_TAKE  = 2'd1,
    POP_FAULT = 2'd2
  } pop_act_e;
endpackage

// File: rtl/dmarf_issue.sv
module dmarf_issue #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_REQ = 4,
  parameter int RLEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              stop,
  input  logic              fire,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [RLEN_W-1:0] cur_len,
  output logic              at_eob,
  output logic              last_req
);
  localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_REQ);

  logic [ADDR_W-1:0] nxt_q, end_q, remain;

  assign remain   = end_q - nxt_q;
  assign last_req = remain <= MAX_A;
  assign cur_len  = last_req ? remain[RLEN_W-1:0] : RLEN_W'(MAX_REQ);
  assign at_eob   = (nxt_q == end_q);
  assign cur_addr = nxt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_q <= '0;
      end_q <= '0;
    end else if (stop) begin
      nxt_q <= end_q;
    end else if (start && at_eob) begin
      nxt_q <= base;
      end_q <= base + ADDR_W'(len);
    end else if (fire) begin
      nxt_q <= nxt_q + ADDR_W'(cur_len);
    end
  end

  // R6
  ignored_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !at_eob && !stop) |=> (end_q == $past(end_q)));

  // R4
  issue_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !at_eob);
endmodule

// File: rtl/dmarf_slots.sv
module dmarf_slots #(
  parameter int MAX_PEND = 4,
  parameter int MAX_REQ  = 4,
  parameter int RLEN_W   = 3,
  parameter int TAG_W    = 2,
  parameter int CNT_W    = 3,
  parameter int RSV_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc,
  input  logic [RLEN_W-1:0]    alloc_len,
  input  logic                 stop,
  input  logic                 rsp_valid,
  input  logic [TAG_W-1:0]     rsp_tag,
  input  logic [8*MAX_REQ-1:0] rsp_data,
  output logic [TAG_W-1:0]     alloc_tag,
  output logic                 full,
  output logic [CNT_W-1:0]     pend_cnt,
  output logic [RSV_W-1:0]     reserved,
  output logic                 drain,
  output logic                 drain_keep,
  output logic [RLEN_W-1:0]    drain_len,
  output logic [8*MAX_REQ-1:0] drain_data
);
  logic                 busy_q [MAX_PEND];
  logic                 done_q [MAX_PEND];
  logic                 drop_q [MAX_PEND];
  logic [RLEN_W-1:0]    len_q  [MAX_PEND];
  logic [8*MAX_REQ-1:0] data_q [MAX_PEND];
  logic [TAG_W-1:0]     head_q, tail_q;
  logic [CNT_W-1:0]     cnt_q;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(MAX_PEND - 1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc_tag  = tail_q;
  assign full       = (cnt_q == CNT_W'(MAX_PEND));
  assign pend_cnt   = cnt_q;
  assign drain      = busy_q[head_q] && done_q[head_q];
  assign drain_keep = !drop_q[head_q];
  assign drain_len  = len_q[head_q];
  assign drain_data = data_q[head_q];

  for (genvar i = 0; i < MAX_PEND; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        drop_q[i] <= 1'b0;
        len_q[i]  <= '0;
      end else if (alloc && tail_q == TAG_W'(i)) begin
        busy_q[i] <= 1'b1;
        done_q[i] <= 1'b0;
        drop_q[i] <= stop;
        len_q[i]  <= alloc_len;
      end else begin
        if (drain && head_q == TAG_W'(i)) busy_q[i] <= 1'b0;
        if (rsp_valid && rsp_tag == TAG_W'(i) && busy_q[i]) done_q[i] <= 1'b1;
        if (stop && busy_q[i]) drop_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rsp_valid && rsp_tag == TAG_W'(i)) data_q[i] <= rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc) tail_q <= bump(tail_q);
      if (drain) head_q <= bump(head_q);
      cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(drain);
    end
  end

  always_comb begin
    reserved = '0;
    for (int i = 0; i < MAX_PEND; i++)
      if (busy_q[i] && !drop_q[i]) reserved = reserved + RSV_W'(len_q[i]);
  end

  // R2
  slot_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);

  // R3
  rsp_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (busy_q[rsp_tag] && !done_q[rsp_tag]));
endmodule

// File: rtl/dmarf_bytefifo.sv
module dmarf_bytefifo #(
  parameter int DEPTH  = 32,
  parameter int WR_MAX = 4,
  parameter int RD_N   = 2,
  parameter int WL_W   = 3,
  parameter int CW     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WL_W-1:0]     wr_len,
  input  logic [8*WR_MAX-1:0] wr_data,
  input  logic                rd_en,
  input  logic                flush,
  output logic [8*RD_N-1:0]   rd_data,
  output logic [CW-1:0]       count
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  assign count = count_q;

  always_ff @(posedge clk) begin
    for (int k = 0; k < WR_MAX; k++)
      if (wr_en && k < int'(wr_len)) mem[wr_ptr_q + AW'(k)] <= wr_data[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= wr_ptr_q + AW'(wr_len);
      if (flush) begin
        rd_ptr_q <= wr_ptr_q;
        count_q  <= wr_en ? CW'(wr_len) : '0;
      end else begin
        if (rd_en) rd_ptr_q <= rd_ptr_q + AW'(RD_N);
        count_q <= count_q + (wr_en ? CW'(wr_len) : '0) - (rd_en ? CW'(RD_N) : '0);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < RD_N; j++) rd_data[8*j +: 8] = mem[rd_ptr_q + AW'(j)];
  end

  // R2
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(count_q) + int'(wr_len) <= DEPTH));

  // R7
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !flush) |-> (int'(count_q) >= RD_N));
endmodule

// File: rtl/dmarf_top.sv
module dmarf_top #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_BYTES = 32,
  parameter int MAX_REQ    = 4,
  parameter int MAX_PEND   = 4,
  parameter int POP_BYTES  = 2,
  localparam int RLEN_W = $clog2(MAX_REQ + 1),
  localparam int TAG_W  = (MAX_PEND > 1) ? $clog2(MAX_PEND) : 1,
  localparam int LVL_W  = $clog2(FIFO_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_start,
  input  logic [ADDR_W-1:0]      cmd_base,
  input  logic [LEN_W-1:0]       cmd_len,
  input  logic                   cmd_stop,
  input  logic                   cmd_flush,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [RLEN_W-1:0]      req_len,
  output logic [TAG_W-1:0]       req_tag,
  input  logic                   rsp_valid,
  input  logic [TAG_W-1:0]       rsp_tag,
  input  logic [8*MAX_REQ-1:0]   rsp_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [8*POP_BYTES-1:0] out_data,
  input  logic                   pop_strict,
  output logic                   pop_err,
  output logic [LVL_W-1:0]       fill_level,
  output logic                   end_of_block,
  output logic                   active,
  output logic                   eob_evt,
  output logic                   idle_evt
);
  import dmarf_pkg::*;

  localparam int CNT_W = $clog2(MAX_PEND + 1);
  localparam int RSV_W = $clog2(MAX_PEND * MAX_REQ + 1);

  logic                 fire, at_eob, last_req, slots_full, space_ok;
  logic                 drain, drain_keep;
  logic [RLEN_W-1:0]    cur_len, drain_len;
  logic [8*MAX_REQ-1:0] drain_data;
  logic [CNT_W-1:0]     pend_cnt;
  logic [RSV_W-1:0]     reserved;
  logic                 eob_q, err_q, act_q;
  pop_act_e             pop_act;

  dmarf_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_REQ(MAX_REQ), .RLEN_W(RLEN_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .base(cmd_base), .len(cmd_len),
    .stop(cmd_stop), .fire(fire), .cur_addr(req_addr), .cur_len(cur_len),
    .at_eob(at_eob), .last_req(last_req)
  );

  dmarf_slots #(.MAX_PEND(MAX_PEND), .MAX_REQ(MAX_REQ), .RLEN_W(RLEN_W),
                .TAG_W(TAG_W), .CNT_W(CNT_W), .RSV_W(RSV_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc(fire), .alloc_len(cur_len), .stop(cmd_stop),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .alloc_tag(req_tag), .full(slots_full), .pend_cnt(pend_cnt), .reserved(reserved),
    .drain(drain), .drain_keep(drain_keep), .drain_len(drain_len), .drain_data(drain_data)
  );

  dmarf_bytefifo #(.DEPTH(FIFO_BYTES), .WR_MAX(MAX_REQ), .RD_N(POP_BYTES),
                   .WL_W(RLEN_W), .CW(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(drain && drain_keep), .wr_len(drain_len),
    .wr_data(drain_data), .rd_en(pop_act == POP_TAKE), .flush(cmd_flush),
    .rd_data(out_data), .count(fill_level)
  );

  // Space check counts stored bytes plus bytes promised to live requests
  assign space_ok  = (32'(fill_level) + 32'(reserved) + 32'(cur_len)) <= 32'(FIFO_BYTES);
  assign req_valid = !at_eob && !slots_full && space_ok;
  assign req_len   = cur_len;
  assign fire      = req_valid && req_ready;

  assign out_valid = 32'(fill_level) >= 32'(POP_BYTES);

  always_comb begin
    if (cmd_flush)                             pop_act = POP_NONE;
    else if (out_valid && (out_ready || pop_strict)) pop_act = POP_TAKE;
    else if (pop_strict)                       pop_act = POP_FAULT;
    else                                       pop_act = POP_NONE;
  end

  assign end_of_block = at_eob;
  assign active       = (pend_cnt != '0) || !at_eob;
  assign eob_evt      = eob_q;
  assign pop_err      = err_q;
  assign idle_evt     = act_q && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eob_q <= 1'b0;
      err_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      eob_q <= fire && last_req && !cmd_stop;
      err_q <= (pop_act == POP_FAULT);
      act_q <= active;
    end
  end

  // R1
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0 && 32'(req_len) <= 32'(MAX_REQ)));

  // R4
  eob_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob_evt |-> end_of_block);

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !eob_evt);

  // R5
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |-> (!active && !req_valid));

  // R8
  strict_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_flush && pop_strict && !out_valid) |=> pop_err);
endmodule

// File: tb/dmarf_top_tb.sv
module dmarf_top_tb;
  localparam int ADDR_W = 32, LEN_W = 16, FIFO_BYTES = 32;
  localparam int MAX_REQ = 4, MAX_PEND = 4, POP_BYTES = 2;
  localparam int RLEN_W = $clog2(MAX_REQ + 1);
  localparam int TAG_W  = $clog2(MAX_PEND);
  localparam int LVL_W  = $clog2(FIFO_BYTES + 1);
  localparam int TBL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_stop = 0, cmd_flush = 0;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic req_valid, req_ready = 0;
  logic [ADDR_W-1:0] req_addr;
  logic [RLEN_W-1:0] req_len;
  logic [TAG_W-1:0]  req_tag;
  logic rsp_valid = 0;
  logic [TAG_W-1:0] rsp_tag = '0;
  logic [8*MAX_REQ-1:0] rsp_data = '0;
  logic out_valid, out_ready = 0, pop_strict = 0, pop_err;
  logic [8*POP_BYTES-1:0] out_data;
  logic [LVL_W-1:0] fill_level;
  logic end_of_block, active, eob_evt, idle_evt;

  dmarf_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_BYTES(FIFO_BYTES), .MAX_REQ(MAX_REQ),
              .MAX_PEND(MAX_PEND), .POP_BYTES(POP_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_base(cmd_base), .cmd_len(cmd_len),
    .cmd_stop(cmd_stop), .cmd_flush(cmd_flush), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .pop_strict(pop_strict), .pop_err(pop_err), .fill_level(fill_level),
    .end_of_block(end_of_block), .active(active), .eob_evt(eob_evt), .idle_evt(idle_evt)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rdy_pct = 100, rsp_pct = 50, pop_pct = 50, max_dly = 6;
  bit rsp_on = 1, pop_on = 1, f_ready = 0, f_strict = 0;
  longint exp_next = 0, exp_end = 0, exp_rd = 0, strm_end = 0;
  bit eob_pend = 0, err_pend = 0;
  int n_eob = 0, n_idle = 0, n_out = 0;
  bit t_use [TBL];
  bit t_drop [TBL];
  int t_tag [TBL], t_len [TBL], t_dly [TBL];
  longint t_addr [TBL];

  function automatic logic [7:0] mem_byte(input longint a);
    logic [31:0] x;
    x = 32'(a);
    return (x[7:0] * 8'd13) ^ x[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cycle();
    bit eob_pre, take, strict_now, ready_now;
    int pick, el, live;
    longint rem;
    logic [8*POP_BYTES-1:0] ev;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
    // outputs from the previous edge
    if (eob_evt || eob_pend) chk("R4", "eob_evt pulse", longint'(eob_evt), longint'(eob_pend));
    if (eob_evt) n_eob++;
    eob_pend = 0;
    if (pop_err || err_pend) chk("R8", "pop_err pulse", longint'(pop_err), longint'(err_pend));
    err_pend = 0;
    chk("R4", "end_of_block level", longint'(end_of_block), longint'(exp_next == exp_end));
    if (idle_evt) begin
      n_idle++;
      chk("R5", "idle with nothing outstanding", n_out, 0);
      chk("R5", "active low at idle", longint'(active), 0);
    end
    // responses, picked out of order
    rsp_valid = 0;
    for (int i = 0; i < TBL; i++) if (t_use[i] && t_dly[i] > 0) t_dly[i]--;
    if (rsp_on && ($urandom % 100) < rsp_pct) begin
      pick = -1;
      for (int s = 0, b = int'($urandom % TBL); s < TBL; s++) begin
        int i;
        i = (b + s) % TBL;
        if (pick < 0 && t_use[i] && t_dly[i] == 0) pick = i;
      end
      if (pick >= 0) begin
        rsp_valid = 1;
        rsp_tag = TAG_W'(t_tag[pick]);
        for (int k = 0; k < MAX_REQ; k++)
          rsp_data[8*k +: 8] = (k < t_len[pick]) ? mem_byte(t_addr[pick] + k) : 8'hEE;
        t_use[pick] = 0;
        n_out--;
      end
    end
    // consumer
    ready_now = 0; strict_now = 0;
    if (f_ready || f_strict) begin
      ready_now = f_ready; strict_now = f_strict;
    end else if (pop_on && out_valid && !cmd_flush && ($urandom % 100) < pop_pct) begin
      if ($urandom % 2 == 0) ready_now = 1; else strict_now = 1;
    end
    out_ready = ready_now; pop_strict = strict_now;
    take = (ready_now || strict_now) && out_valid && !cmd_flush;
    if (take) begin
      for (int j = 0; j < POP_BYTES; j++) ev[8*j +: 8] = mem_byte(exp_rd + j);
      chk("R3", "chunk data in address order", longint'(out_data), longint'(ev));
      exp_rd += POP_BYTES;
    end
    if (strict_now && !out_valid && !cmd_flush) err_pend = 1;
    if (cmd_flush) exp_rd += longint'(fill_level);
    req_ready = (($urandom % 100) < rdy_pct);
    #1;
    eob_pre = (exp_next == exp_end);
    if (req_valid && req_ready) begin
      rem = exp_end - exp_next;
      el = (rem < MAX_REQ) ? int'(rem) : MAX_REQ;
      live = 0;
      for (int i = 0; i < TBL; i++) if (t_use[i] && !t_drop[i]) live += t_len[i];
      chk("R1", "request address", longint'(req_addr), exp_next);
      chk("R1", "request length", longint'(req_len), el);
      chk("R2", "outstanding within limit", longint'(n_out < MAX_PEND), 1);
      chk("R2", "space reserved", longint'(int'(fill_level) + live + int'(req_len) <= FIFO_BYTES), 1);
      pick = -1;
      for (int i = 0; i < TBL; i++) if (pick < 0 && !t_use[i]) pick = i;
      t_use[pick] = 1; t_drop[pick] = cmd_stop; t_tag[pick] = int'(req_tag);
      t_addr[pick] = exp_next; t_len[pick] = el; t_dly[pick] = int'($urandom % max_dly);
      n_out++;
      exp_next += el;
      if (exp_next == exp_end && !cmd_stop) eob_pend = 1;
    end
    if (cmd_stop) begin
      exp_next = exp_end;
      for (int i = 0; i < TBL; i++) t_drop[i] = 1;
    end else if (cmd_start && eob_pre) begin
      exp_next = longint'(cmd_base);
      exp_end  = longint'(cmd_base) + longint'(cmd_len);
    end
    @(posedge clk);
    #1;
    cmd_start = 0; cmd_stop = 0; cmd_flush = 0;
    f_ready = 0; f_strict = 0;
  endtask

  task automatic start_blk(input longint base, input int len);
    cmd_start = 1; cmd_base = ADDR_W'(base); cmd_len = LEN_W'(len);
    cycle();
  endtask

  task automatic drain_all(input int limit);
    int i;
    i = 0;
    while (!(exp_rd == strm_end && n_out == 0 && !active) && i < limit) begin
      cycle();
      i++;
    end
    chk("R3", "block fully delivered", longint'(i < limit), 1);
  endtask

  initial begin
    int seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < TBL; i++) t_use[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R4", "eob after reset", longint'(end_of_block), 1);
    chk("R5", "inactive after reset", longint'(active), 0);
    chk("R10", "level after reset", longint'(fill_level), 0);
    chk("R7", "no chunk after reset", longint'(out_valid), 0);
    chk("R1", "no request after reset", longint'(req_valid), 0);
    @(posedge clk); #1;

    // try-pop and strict pop on empty FIFO
    f_ready = 1; cycle();
    cycle();
    chk("R7", "try-pop on empty leaves level", longint'(fill_level), 0);
    f_strict = 1; cycle();
    cycle();
    chk("R8", "strict pop on empty leaves level", longint'(fill_level), 0);

    // single block larger than the FIFO
    n_eob = 0; n_idle = 0;
    exp_rd = 'h100; strm_end = 'h100 + 40;
    start_blk('h100, 40);
    drain_all(2000);
    chk("R4", "one eob event per block", n_eob, 1);
    chk("R5", "one idle event per block", n_idle, 1);

    // illegal start mid-block, then a chained start with responses held back
    n_eob = 0; n_idle = 0; pop_on = 0; rsp_on = 0;
    exp_rd = 'h200; strm_end = 'h210 + 18;
    start_blk('h200, 16);
    cmd_start = 1; cmd_base = 'h900; cmd_len = 8;
    cycle();
    chk("R6", "start ignored mid-block", longint'(end_of_block), 0);
    for (int i = 0; i < 50 && n_eob == 0; i++) cycle();
    chk("R6", "slots still pending at chained start", n_out, MAX_PEND);
    chk("R6", "active at chained start", longint'(active), 1);
    start_blk('h210, 18);
    rsp_on = 1; pop_on = 1;
    drain_all(2000);
    chk("R4", "two eob events for chain", n_eob, 2);
    chk("R5", "no idle between chained blocks", n_idle, 1);

    // fill to capacity, then flush
    pop_on = 0; rsp_pct = 100; max_dly = 1;
    exp_rd = 'h300; strm_end = 'h300 + 40;
    start_blk('h300, 40);
    repeat (60) cycle();
    chk("R2", "FIFO filled to capacity", longint'(fill_level), FIFO_BYTES);
    chk("R2", "no request when full", longint'(req_valid), 0);
    chk("R2", "nothing outstanding when full", n_out, 0);
    cmd_flush = 1; cycle();
    cycle();
    chk("R10", "level after flush", longint'(fill_level), 0);
    pop_on = 1;
    drain_all(2000);

    // stop with every slot occupied
    pop_on = 0; rsp_on = 0; max_dly = 6; rsp_pct = 50;
    exp_rd = 'h400; strm_end = 'h400;
    start_blk('h400, 40);
    repeat (10) cycle();
    chk("R9", "slots full before stop", n_out, MAX_PEND);
    n_eob = 0; n_idle = 0;
    cmd_stop = 1; cycle();
    chk("R9", "eob after stop", longint'(end_of_block), 1);
    chk("R9", "no request after stop", longint'(req_valid), 0);
    rsp_on = 1; rsp_pct = 100;
    repeat (30) cycle();
    chk("R9", "late responses discarded", longint'(fill_level), 0);
    chk("R9", "idle after last late response", n_idle, 1);
    chk("R9", "no eob event after stop", n_eob, 0);
    chk("R9", "inactive after stop", longint'(active), 0);
    pop_on = 1;

    // random blocks
    for (int b = 0; b < 12; b++) begin
      longint base;
      int len;
      base = longint'($urandom % 4096);
      len = 2 * (1 + int'($urandom % 24));
      rdy_pct = 40 + int'($urandom % 61);
      rsp_pct = 30 + int'($urandom % 71);
      pop_pct = 20 + int'($urandom % 81);
      max_dly = 1 + int'($urandom % 8);
      n_eob = 0; n_idle = 0;
      exp_rd = base; strm_end = base + len;
      start_blk(base, len);
      drain_all(4000);
      chk("R4", "random block eob count", n_eob, 1);
      chk("R5", "random block idle count", n_idle, 1);
    end
    summary();
  end
endmodule